// File: doc/BRIEF.md
# Quad DAC serial command interface

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter. A host shifts 12-bit command words in on a serial clock while chip select is held low. Nothing happens to the register bank while the word is arriving. When chip select returns high, the word in the shift register is decoded and applied to a double-buffered bank. The bank holds four staging (input) registers and four output (DAC) registers. The DAC register values leave the block as one flat bus for the converters.

The serial output carries the most significant bit of the shift register, so several parts can share one chip select in a daisy chain. A word that passes through a part reappears at its serial output twelve serial clocks later. A no-operation word leaves a part untouched. The clock edge on which the serial output changes can be selected. An asynchronous active-low load strobe copies all four staging registers into the output registers at once.

All serial inputs are brought into the system clock domain through two-flop synchronizers. Their edges are detected there, so every effect appears three system clocks after the pin change that causes it.

Top module: `sdac_front`

## Requirements
- R1: Words are 12 bits long and the first bit shifted in is the most significant. Bits [11:10] hold the channel address, bits [9:8] the control code and bits [7:0] the data. A bit is captured on each rising serial clock edge while chip select is low.
- R2: No staging or output register changes while a word is being shifted. The decoded word acts only on the rising edge of chip select, using the current contents of the shift register.
- R3: Control code 01 writes the data into the addressed staging register only. Every output register keeps its value.
- R4: Control code 11 writes the data into both the addressed staging register and the addressed output register.
- R5: Control code 10 writes the data into all four output registers, whatever the address. The staging registers are unchanged, and data 0x00 clears every channel.
- R6: Address 00 with control 00 is a no-operation: no register changes.
- R7: Address 01 with control 00 copies every staging register into its output register.
- R8: Address 10 with control 00 selects serial output on the rising serial clock edge. Address 11 with control 00 selects the falling edge. Both also copy every staging register into its output register.
- R9: A falling edge on the load strobe copies every staging register into its output register.
- R10: The serial output takes the shift register's most significant bit on the selected serial clock edge while chip select is low. A word therefore reappears at the output, first bit first, during the next twelve serial clocks.
- R11: If a load strobe falling edge and a chip select rising edge are seen in the same cycle, the command's writes happen first. The copy then uses the updated staging registers.
- R12: After reset all registers are zero, the serial output is 0 and the rising-edge output mode is active.
- R13: Serial clock edges seen while chip select is high change neither the shift register nor the serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, oversampled by clk |
| cs_n | input | 1 | Active-low chip select; its rising edge commits a word |
| din | input | 1 | Serial data in |
| ldac_n | input | 1 | Asynchronous active-low load strobe |
| dout | output | 1 | Serial data out for daisy chaining |
| dac_flat | output | 32 | Output registers; channel i on bits [8i+7:8i] |

## Verification
The assertions check, on every cycle, the properties that hold at all times. Staging and output registers stay put without a commit or load. The output mode only moves on a commit. After a load, every output register equals its staging register. The shift register and the serial output hold still when no qualifying serial clock edge arrives. Only the bench's scenarios can show the decode of each code word and the field order. They also cover the ordering when a commit and a load strobe coincide, and the exact bit sequence seen at the serial output in both phase modes. A behavioural model follows every pin through the synchronizer latency and is compared each clock.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int DAC_W  = 8;
    localparam int NUM_CH = 4;
    localparam int ADDR_W = $clog2(NUM_CH);
    localparam int CTL_W  = 2;
    localparam int WORD_W = ADDR_W + CTL_W + DAC_W;
    localparam int BUS_W  = NUM_CH * DAC_W;

    typedef logic [DAC_W-1:0]              dac_t;
    typedef logic [NUM_CH-1:0][DAC_W-1:0]  bank_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CTL_W-1:0]  ctl;
        dac_t              data;
    } cmd_t;

    typedef enum logic [2:0] {
        OP_NOP, OP_STAGE, OP_STAGE_OUT, OP_BCAST,
        OP_LOAD, OP_LOAD_RISE, OP_LOAD_FALL
    } op_t;

    typedef enum logic { PH_RISE = 1'b0, PH_FALL = 1'b1 } phase_t;

    function automatic op_t decode(cmd_t c);
        op_t op;
        case (c.ctl)
            2'b01:   op = OP_STAGE;
            2'b11:   op = OP_STAGE_OUT;
            2'b10:   op = OP_BCAST;
            default: begin
                case (c.addr)
                    2'd0:    op = OP_NOP;
                    2'd1:    op = OP_LOAD;
                    2'd2:    op = OP_LOAD_RISE;
                    default: op = OP_LOAD_FALL;
                endcase
            end
        endcase
        return op;
    endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int           W       = 4,
    parameter int           NPREV   = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     d_i,
    output logic [W-1:0]     q_o,
    output logic [NPREV-1:0] prev_o
);
    logic [W-1:0]     s1_q, s2_q;
    logic [NPREV-1:0] p_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
            p_q  <= RST_VAL[NPREV-1:0];
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
            p_q  <= s2_q[NPREV-1:0];
        end
    end

    assign q_o    = s2_q;
    assign prev_o = p_q;
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
    import sdac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic launch_en,
    input  logic din_i,
    output cmd_t word_o,
    output logic dout_o
);
    logic [WORD_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            dout_o <= 1'b0;
        end else begin
            if (launch_en) dout_o <= sr_q[WORD_W-1];
            if (shift_en)  sr_q   <= {sr_q[WORD_W-2:0], din_i};
        end
    end

    assign word_o = cmd_t'(sr_q);

    AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sr_q)) else $error("shift register moved"); // R13
endmodule

// File: rtl/sdac_bank.sv
module sdac_bank
    import sdac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   commit_i,
    input  cmd_t   cmd_i,
    input  logic   load_i,
    output bank_t  out_o,
    output phase_t phase_o
);
    bank_t  stage_q, stage_n, out_n;
    phase_t ph_n;
    op_t    op;

    assign op = decode(cmd_i);

    always_comb begin
        stage_n = stage_q;
        out_n   = out_o;
        ph_n    = phase_o;
        if (commit_i) begin
            case (op)
                OP_STAGE:     stage_n[cmd_i.addr] = cmd_i.data;
                OP_STAGE_OUT: begin
                    stage_n[cmd_i.addr] = cmd_i.data;
                    out_n[cmd_i.addr]   = cmd_i.data;
                end
                OP_BCAST:     for (int i = 0; i < NUM_CH; i++) out_n[i] = cmd_i.data;
                OP_LOAD:      out_n = stage_q;
                OP_LOAD_RISE: begin out_n = stage_q; ph_n = PH_RISE; end
                OP_LOAD_FALL: begin out_n = stage_q; ph_n = PH_FALL; end
                default:      ;
            endcase
        end
        if (load_i) out_n = stage_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            out_o   <= '0;
            phase_o <= PH_RISE;
        end else begin
            stage_q <= stage_n;
            out_o   <= out_n;
            phase_o <= ph_n;
        end
    end

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(stage_q)) else $error("staging moved"); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!commit_i && !load_i) |=> $stable(out_o)) else $error("output moved"); // R2
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (out_o == stage_q)) else $error("load copy wrong"); // R9
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(phase_o)) else $error("mode moved"); // R8
endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             din,
    input  logic             ldac_n,
    output logic             dout,
    output logic [BUS_W-1:0] dac_flat
);
    logic [3:0] lvl;
    logic [2:0] prev;
    logic       sclk_rise, sclk_fall, cs_rise, ldac_fall, cs_low;
    logic       shift_en, launch_en;
    cmd_t       word;
    bank_t      outs;
    phase_t     phase;

    sdac_sync #(.W(4), .NPREV(3), .RST_VAL(4'b0110)) u_sync (
        .clk(clk), .rst(rst),
        .d_i({din, ldac_n, cs_n, sclk}),
        .q_o(lvl), .prev_o(prev)
    );

    assign sclk_rise = lvl[0] & ~prev[0];
    assign sclk_fall = ~lvl[0] & prev[0];
    assign cs_rise   = lvl[1] & ~prev[1];
    assign ldac_fall = ~lvl[2] & prev[2];
    assign cs_low    = ~lvl[1];
    assign shift_en  = cs_low & sclk_rise;
    assign launch_en = cs_low & ((phase == PH_RISE) ? sclk_rise : sclk_fall);

    sdac_shift u_shift (
        .clk(clk), .rst(rst),
        .shift_en(shift_en), .launch_en(launch_en), .din_i(lvl[3]),
        .word_o(word), .dout_o(dout)
    );

    sdac_bank u_bank (
        .clk(clk), .rst(rst),
        .commit_i(cs_rise), .cmd_i(word), .load_i(ldac_fall),
        .out_o(outs), .phase_o(phase)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            assign dac_flat[g*DAC_W +: DAC_W] = outs[g];
        end
    endgenerate

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !launch_en |=> $stable(dout)) else $error("dout moved"); // R10
endmodule

// File: tb/sdac_front_tb.sv
module sdac_front_tb_top;
    localparam int H = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, cs_n = 1'b1, din = 1'b0, ldac_n = 1'b1;
    logic        dout;
    logic [31:0] dac_flat;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    logic cap_lo [12];
    logic cap_hi [12];

    always #4 clk = ~clk;

    sdac_front dut_i (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
        .ldac_n(ldac_n), .dout(dout), .dac_flat(dac_flat)
    );

    // behavioural reference
    logic [3:0]  hq[$];
    logic [7:0]  m_in  [4];
    logic [7:0]  m_dac [4];
    logic [11:0] m_sr;
    logic        m_dout, m_fall;

    always @(posedge clk) begin
        logic [3:0] a, b;
        if (rst) begin
            hq.delete();
            for (int i = 0; i < 4; i++) hq.push_back(4'b0110);
            for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_dac[i] = 0; end
            m_sr = 0; m_dout = 0; m_fall = 0;
        end else begin
            hq.push_back({din, ldac_n, cs_n, sclk});
            void'(hq.pop_front());
            a = hq[1];
            b = hq[0];
            if (!a[1] && (m_fall ? (!a[0] && b[0]) : (a[0] && !b[0]))) m_dout = m_sr[11];
            if (!a[1] && a[0] && !b[0]) m_sr = {m_sr[10:0], a[3]};
            if (a[1] && !b[1]) begin
                int ad;
                ad = int'(m_sr[11:10]);
                case (m_sr[9:8])
                    2'b01: m_in[ad] = m_sr[7:0];
                    2'b11: begin m_in[ad] = m_sr[7:0]; m_dac[ad] = m_sr[7:0]; end
                    2'b10: for (int i = 0; i < 4; i++) m_dac[i] = m_sr[7:0];
                    default: if (ad != 0) begin
                        for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
                        if (ad == 2) m_fall = 0;
                        if (ad == 3) m_fall = 1;
                    end
                endcase
            end
            if (!a[2] && b[2]) for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic [31:0] exp;
            exp = {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
            compared += 2;
            if (dac_flat !== exp) begin
                mismatched++;
                $display("FAIL R2 model dac_flat actual %h expected %h", dac_flat, exp);
            end
            if (dout !== m_dout) begin
                mismatched++;
                $display("FAIL R10 model dout actual %b expected %b", dout, m_dout);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [11:0] w, input bit close_cs);
        cs_n = 1'b0;
        waitn(H);
        for (int k = 0; k < 12; k++) begin
            din = w[11-k];
            sclk = 1'b0;
            waitn(H);
            cap_lo[k] = dout;
            sclk = 1'b1;
            waitn(H);
            cap_hi[k] = dout;
        end
        sclk = 1'b0;
        waitn(H);
        if (close_cs) begin
            cs_n = 1'b1;
            waitn(8);
        end
    endtask

    task automatic chk_daisy(input string tag, input logic [11:0] w1, input bit use_lo);
        for (int k = 1; k <= 12; k++)
            chk(tag, {31'd0, use_lo ? cap_lo[k-1] : cap_hi[k-1]}, {31'd0, w1[12-k]});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL R1 watchdog actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        waitn(4);
        rst = 1'b0;
        waitn(2);
        chk("R12 reset dac", dac_flat, 32'h0);
        chk("R12 reset dout", {31'd0, dout}, 32'h0);

        // R1 / R3: staging writes per channel
        send(12'h111, 1); send(12'h522, 1); send(12'h933, 1); send(12'hD44, 1);
        chk("R3 staging only", dac_flat, 32'h0);

        send(12'h400, 1);
        chk("R7 software load", dac_flat, 32'h44332211);

        send(12'hBA5, 0);
        chk("R2 before cs rise", dac_flat, 32'h44332211);
        cs_n = 1'b1;
        waitn(8);
        chk("R4 stage and output", dac_flat, 32'h44A52211);

        send(12'hE7E, 1);
        chk("R5 broadcast", dac_flat, 32'h7E7E7E7E);
        send(12'h600, 1);
        chk("R5 broadcast clear", dac_flat, 32'h0);
        send(12'h4FF, 1);
        chk("R5 staging untouched", dac_flat, 32'h44A52211);

        send(12'h0FF, 1);
        chk("R6 nop", dac_flat, 32'h44A52211);

        send(12'h15A, 1);
        chk("R3 stage ch0", dac_flat, 32'h44A52211);
        ldac_n = 1'b0; waitn(6); ldac_n = 1'b1; waitn(6);
        chk("R9 load strobe", dac_flat, 32'h44A5225A);

        send(12'hD77, 0);
        cs_n = 1'b1; ldac_n = 1'b0;
        waitn(6); ldac_n = 1'b1; waitn(6);
        chk("R11 commit then load", dac_flat, 32'h77A5225A);

        // R13: serial clocks with chip select high are ignored
        din = 1'b1;
        for (int k = 0; k < 5; k++) begin
            sclk = 1'b1; waitn(H); sclk = 1'b0; waitn(H);
        end
        chk("R13 dout held", {31'd0, dout}, 32'h0);
        send(12'h0C3, 1);
        chk_daisy("R10 R13 rising daisy", 12'hD77, 0);

        send(12'hC00, 1);
        chk("R8 falling select load", dac_flat, 32'h77A5225A);
        send(12'h0C3, 1);
        chk_daisy("R8 R10 falling daisy", 12'hC00, 1);

        send(12'h533, 1);
        send(12'h800, 1);
        chk("R8 rising select load", dac_flat, 32'h77A5335A);
        send(12'h0C3, 1);
        chk_daisy("R8 R10 rising daisy", 12'h800, 0);
        chk("R6 nop after daisy", dac_flat, 32'h77A5335A);

        waitn(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule